// File: doc/BRIEF.md
# BCD Seven-Segment Display Driver

This block turns one 4-bit 8421 BCD digit into the seven segment drive lines of a common-anode display, so every segment output is active-low (0 lights the segment). It has three controls besides the digit. A lamp-test control lights every segment, so burned-out segments can be found. A forced-blank control turns the display off. A ripple-blank input lets a digit position suppress a zero that carries no information.

Several copies chain into a multi-digit readout that hides leading zeros. The ripple output of each position feeds the ripple input of the next lower-order position. The most significant position has its ripple input tied low. The least significant position has its ripple input tied high, so a value of zero still shows a single "0". On a package pin the forced-blank input and the ripple output would share one open-drain line. Here they are two separate ports, and the ripple output copies a forced blank just as the shared pin would. The decode is purely combinational and has no clock and no state.

Top module: `seg7_bcd_driver`

## Requirements
- R1: With all controls inactive (lamp_test_n_i, rbi_n_i and blank_n_i all high), codes 0 to 9 drive seg_n_o = {g,f,e,d,c,b,a} (bit 0 is segment a, a 0 bit is a lit segment). The lit sets are: 0 a,b,c,d,e,f; 1 b,c; 2 a,b,d,e,g; 3 a,b,c,d,g; 4 b,c,f,g; 5 a,c,d,f,g; 6 a,c,d,e,f,g; 7 a,b,c; 8 all seven; 9 a,b,c,d,f,g.
- R2: Codes 1010 to 1111 turn every segment off (seg_n_o = 7'h7F) and leave rbo_n_o high, whatever the level of rbi_n_i.
- R3: When blank_n_i is high and lamp_test_n_i is low, seg_n_o = 7'h00 and rbo_n_o is high. This holds for any code and any rbi_n_i level, so lamp test overrides ripple blanking.
- R4: When blank_n_i is low, seg_n_o = 7'h7F and rbo_n_o is low. Lamp test, ripple input and code have no effect, so forced blank has the highest priority.
- R5: When blank_n_i and lamp_test_n_i are high, rbi_n_i is low and the code is 0000, every segment is off and rbo_n_o is low.
- R6: A low rbi_n_i has no effect on a nonzero code: the digit shows as in R1 (or blanks as in R2) and rbo_n_o stays high.
- R7: With rbi_n_i high, code 0000 shows the digit 0 (seg_n_o = 7'h40) and rbo_n_o is high.
- R8: In a four-digit chain (most significant ripple input low, each ripple output into the next lower ripple input, least significant ripple input high), every zero above the first nonzero digit is blank. Zeros below it are shown, and the least significant digit is always shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_i | input | 4 | BCD digit code, 8421 weighting |
| lamp_test_n_i | input | 1 | Lamp test, active-low |
| rbi_n_i | input | 1 | Ripple-blank input from the higher-order digit, active-low |
| blank_n_i | input | 1 | Forced blank, active-low |
| seg_n_o | output | 7 | Segment drive {g,f,e,d,c,b,a}, active-low |
| rbo_n_o | output | 1 | Ripple-blank output to the lower-order digit, active-low |

## Verification
The block holds no state, so a wrong internal decision shows at the ports as soon as the inputs settle. A wrong glyph bit shows as one segment out of place on one code. A wrong priority shows as lamp test beating forced blank, or ripple blanking beating lamp test. A broken zero detect shows as a blanked digit that carries value, or as a dropped or spurious low on rbo_n_o. In the chained bench such a fault spreads downward, so a wrong ripple decision in a high position changes the visible digits below it on the same input pattern.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SEG_N   = 7;
  localparam int unsigned DIG_MAX = 9;

  typedef logic [SEG_N-1:0]  seg_t;   // {g,f,e,d,c,b,a}
  typedef logic [CODE_W-1:0] code_t;

  localparam seg_t SEG_NONE = '0;
  localparam seg_t SEG_ALL  = '1;

  typedef enum logic [1:0] {
    DRV_GLYPH = 2'd0,
    DRV_DARK  = 2'd1,
    DRV_LAMP  = 2'd2
  } drive_mode_e;
endpackage

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
(
  input  code_t code_i,
  output seg_t  glyph_o,   // active-high lit pattern, empty for invalid codes
  output logic  zero_o
);
  always_comb begin
    unique case (code_i)
      4'd0:    glyph_o = 7'b0111111;
      4'd1:    glyph_o = 7'b0000110;
      4'd2:    glyph_o = 7'b1011011;
      4'd3:    glyph_o = 7'b1001111;
      4'd4:    glyph_o = 7'b1100110;
      4'd5:    glyph_o = 7'b1101101;
      4'd6:    glyph_o = 7'b1111101;
      4'd7:    glyph_o = 7'b0000111;
      4'd8:    glyph_o = 7'b1111111;
      4'd9:    glyph_o = 7'b1101111;
      default: glyph_o = SEG_NONE;
    endcase
  end

  assign zero_o = (code_i == '0);
endmodule

// File: rtl/seg7_blank_ctrl.sv
module seg7_blank_ctrl
  import seg7_pkg::*;
(
  input  logic        zero_i,
  input  logic        lamp_test_n_i,
  input  logic        rbi_n_i,
  input  logic        blank_n_i,
  output drive_mode_e mode_o,
  output logic        rbo_n_o
);
  logic ripple_hit;

  // ripple blanking applies only to a zero digit and only outside lamp test
  assign ripple_hit = zero_i & ~rbi_n_i & lamp_test_n_i;

  always_comb begin
    if (!blank_n_i)          mode_o = DRV_DARK;
    else if (!lamp_test_n_i) mode_o = DRV_LAMP;
    else if (ripple_hit)     mode_o = DRV_DARK;
    else                     mode_o = DRV_GLYPH;
  end

  // a forced blank reads back low, as a shared open-drain line would
  assign rbo_n_o = ~(~blank_n_i | ripple_hit);
endmodule

// File: rtl/seg7_bcd_driver.sv
module seg7_bcd_driver
  import seg7_pkg::*;
(
  input  logic [3:0] bcd_i,
  input  logic       lamp_test_n_i,
  input  logic       rbi_n_i,
  input  logic       blank_n_i,
  output logic [6:0] seg_n_o,
  output logic       rbo_n_o
);
  seg_t        glyph;
  logic        is_zero;
  drive_mode_e mode;

  seg7_glyph_rom u_rom (
    .code_i  (bcd_i),
    .glyph_o (glyph),
    .zero_o  (is_zero)
  );

  seg7_blank_ctrl u_ctrl (
    .zero_i        (is_zero),
    .lamp_test_n_i (lamp_test_n_i),
    .rbi_n_i       (rbi_n_i),
    .blank_n_i     (blank_n_i),
    .mode_o        (mode),
    .rbo_n_o       (rbo_n_o)
  );

  // one output stage per segment, inverting for the common-anode drive
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_comb begin
      unique case (mode)
        DRV_LAMP:  seg_n_o[s] = 1'b0;
        DRV_DARK:  seg_n_o[s] = 1'b1;
        default:   seg_n_o[s] = ~glyph[s];
      endcase
    end
  end
endmodule

// File: rtl/seg7_bcd_driver_chk.sv
module seg7_bcd_driver_chk (
  input logic [3:0] bcd_i,
  input logic       lamp_test_n_i,
  input logic       rbi_n_i,
  input logic       blank_n_i,
  input logic [6:0] seg_n_o,
  input logic       rbo_n_o
);
  always_comb begin
    if (blank_n_i == 1'b0)
      assert_blank_wins_R4: assert (seg_n_o == 7'h7F && rbo_n_o == 1'b0)
        else $error("forced blank not honoured");

    if (blank_n_i == 1'b1 && lamp_test_n_i == 1'b0)
      assert_lamp_all_on_R3: assert (seg_n_o == 7'h00 && rbo_n_o == 1'b1)
        else $error("lamp test not honoured");

    if (blank_n_i == 1'b1 && lamp_test_n_i == 1'b1 && bcd_i > 4'd9)
      assert_invalid_dark_R2: assert (seg_n_o == 7'h7F && rbo_n_o == 1'b1)
        else $error("invalid code lit a segment");

    if (blank_n_i == 1'b1 && rbo_n_o == 1'b0)
      assert_ripple_only_zero_R5: assert (bcd_i == 4'd0 && rbi_n_i == 1'b0 && seg_n_o == 7'h7F)
        else $error("ripple output low without a blanked zero");

    if (blank_n_i == 1'b1 && lamp_test_n_i == 1'b1 && bcd_i <= 4'd9 && bcd_i != 4'd0)
      assert_digit_lit_R6: assert ($countones(~seg_n_o) >= 2 && rbo_n_o == 1'b1)
        else $error("nonzero digit not shown");
  end
endmodule

bind seg7_bcd_driver seg7_bcd_driver_chk u_chk (
  .bcd_i         (bcd_i),
  .lamp_test_n_i (lamp_test_n_i),
  .rbi_n_i       (rbi_n_i),
  .blank_n_i     (blank_n_i),
  .seg_n_o       (seg_n_o),
  .rbo_n_o       (rbo_n_o)
);

// File: tb/seg7_bcd_driver_bench.sv
module seg7_bcd_driver_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // single driver under test
  logic [3:0] bcd = 4'd0;
  logic lt_n = 1'b1, rbi_n = 1'b1, bi_n = 1'b1;
  logic [6:0] seg_n;
  logic rbo_n;

  seg7_bcd_driver u_seg7_bcd_driver (
    .bcd_i(bcd), .lamp_test_n_i(lt_n), .rbi_n_i(rbi_n), .blank_n_i(bi_n),
    .seg_n_o(seg_n), .rbo_n_o(rbo_n)
  );

  // four-digit chain, index 3 is most significant
  logic [15:0] cval = 16'h0000;
  logic        c_lt_n = 1'b1;
  logic [6:0]  cseg [4];
  logic [3:0]  crbo;
  logic [3:0]  crbi;
  assign crbi = {1'b0, crbo[3], crbo[2], 1'b1};

  for (genvar k = 0; k < 4; k++) begin : g_chain
    seg7_bcd_driver u_dig (
      .bcd_i(cval[4*k +: 4]), .lamp_test_n_i(c_lt_n), .rbi_n_i(crbi[k]),
      .blank_n_i(1'b1), .seg_n_o(cseg[k]), .rbo_n_o(crbo[k])
    );
  end

  // lit pattern {g..a}, active-high, from R1
  function automatic logic [6:0] lit_of(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B; 4'd3: return 7'h4F;
      4'd4: return 7'h66; 4'd5: return 7'h6D; 4'd6: return 7'h7D; 4'd7: return 7'h07;
      4'd8: return 7'h7F; 4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // {req[3:0], bcd[3:0], lt_n, rbi_n, bi_n, seg_n[6:0], rbo_n}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {4'd7, 4'd0, 1'b1, 1'b1, 1'b1, 7'h40, 1'b1},   // R7 zero shown
    {4'd5, 4'd0, 1'b1, 1'b0, 1'b1, 7'h7F, 1'b0},   // R5 zero rippled off
    {4'd3, 4'd0, 1'b0, 1'b0, 1'b1, 7'h00, 1'b1},   // R3 lamp beats ripple
    {4'd6, 4'd7, 1'b1, 1'b0, 1'b1, 7'h78, 1'b1},   // R6
    {4'd6, 4'd9, 1'b1, 1'b0, 1'b1, 7'h10, 1'b1},   // R6
    {4'd2, 4'hA, 1'b1, 1'b1, 1'b1, 7'h7F, 1'b1},   // R2
    {4'd2, 4'hF, 1'b1, 1'b0, 1'b1, 7'h7F, 1'b1},   // R2 with ripple low
    {4'd3, 4'd5, 1'b0, 1'b1, 1'b1, 7'h00, 1'b1},   // R3
    {4'd3, 4'hC, 1'b0, 1'b1, 1'b1, 7'h00, 1'b1},   // R3 invalid code
    {4'd4, 4'd3, 1'b0, 1'b1, 1'b0, 7'h7F, 1'b0},   // R4 beats lamp
    {4'd4, 4'd8, 1'b1, 1'b1, 1'b0, 7'h7F, 1'b0},   // R4
    {4'd4, 4'd0, 1'b1, 1'b0, 1'b0, 7'h7F, 1'b0},   // R4 with ripple
    {4'd1, 4'd2, 1'b1, 1'b1, 1'b1, 7'h24, 1'b1},   // R1
    {4'd1, 4'd6, 1'b1, 1'b1, 1'b1, 7'h02, 1'b1}    // R1
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_chain(input logic [15:0] v, input logic lt);
    bit lead = 1'b1;
    cval = v; c_lt_n = lt;
    #1;
    for (int k = 3; k >= 0; k--) begin
      logic [3:0] d = v[4*k +: 4];
      logic [6:0] e;
      if (!lt) e = 7'h00;
      else if (lead && d == 4'd0 && k != 0) e = 7'h7F;
      else e = ~lit_of(d);
      if (d != 4'd0) lead = 1'b0;
      check("R8", $sformatf("chain %h digit %0d", v, k), {1'b0, cseg[k]}, {1'b0, e});
    end
    @(posedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // idle state with all controls inactive and code 0: R7
    check("R7", "idle seg", {1'b0, seg_n}, 8'h40);
    check("R7", "idle rbo", {7'b0, rbo_n}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v = VEC[i];
      @(negedge clk);
      bcd = v[14:11]; lt_n = v[10]; rbi_n = v[9]; bi_n = v[8];
      #1;
      check($sformatf("R%0d", v[18:15]), $sformatf("vec %0d seg", i), {1'b0, seg_n}, {1'b0, v[7:1]});
      check($sformatf("R%0d", v[18:15]), $sformatf("vec %0d rbo", i), {7'b0, rbo_n}, {7'b0, v[0]});
    end

    // every code with controls inactive: R1 and R2
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      bcd = d[3:0]; lt_n = 1'b1; rbi_n = 1'b1; bi_n = 1'b1;
      #1;
      check(d < 10 ? "R1" : "R2", $sformatf("code %0d", d), {1'b0, seg_n}, {1'b0, ~lit_of(d[3:0])});
      check(d < 10 ? "R1" : "R2", $sformatf("code %0d rbo", d), {7'b0, rbo_n}, 8'h01);
    end

    // ripple low on every nonzero code: R6
    for (int d = 1; d < 16; d++) begin
      @(negedge clk);
      bcd = d[3:0]; rbi_n = 1'b0;
      #1;
      check("R6", $sformatf("ripple code %0d", d), {rbo_n, seg_n}, {1'b1, ~lit_of(d[3:0])});
    end

    // chained leading-zero suppression: R8, lamp override R3
    @(negedge clk);
    run_chain(16'h0042, 1'b1);
    run_chain(16'h0000, 1'b1);
    run_chain(16'h1005, 1'b1);
    run_chain(16'h0500, 1'b1);
    run_chain(16'h0009, 1'b1);
    run_chain(16'h9999, 1'b1);
    run_chain(16'h0000, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule